// File: doc/BRIEF.md
# Power-Mode Sequencer with Interrupt Wake-Up

This block decides when a small 8-bit controller stops its main oscillator and when it starts it again. The CPU writes a power-down request. While the watchdog is off, the block shuts both the high-frequency oscillator and the CPU clock. It then watches the external interrupt lines and the seconds tick, all clocked by the always-running low-frequency clock. When a wake-up source qualifies, the block restarts the oscillator and counts a stabilization window. At the end of the window it either resumes the CPU with a wake-up request to the interrupt controller, falls back to idle, or returns to power-down.

Only a level-sensitive, enabled external line can wake the device. The seconds tick can wake it only when it is enabled and external line 1 is level-sensitive. After stabilization, the block compares the waking source's priority with the interrupt already in service. If the in-service interrupt is of equal or higher rank, the block parks in idle: the oscillator runs but the CPU clock stays gated. It leaves idle only for a source that outranks the one in service.

The block has no registers of its own, so register and RAM contents are untouched by any wake-up. An external reset returns the block to run.

Top module: `pwr_seq`

## Requirements
- R1: In run (mode code 0), a cycle with `pd_req`=1 and `wdt_en`=0 moves the block to power-down (mode code 2) at the next edge. Power-down drives `osc_en`=0 and `cpu_clk_en`=0.
- R2: In run, `pd_req`=1 is ignored while `wdt_en`=1: the mode stays 0 and the CPU clock stays on.
- R3: In power-down, an external line that is low but disabled, or configured edge-triggered (`extN_lvl`=0), leaves the mode at 2.
- R4: In power-down, a qualified source moves the block to oscillator wait (mode code 3) at the next edge, with `osc_en`=1, `cpu_clk_en`=0 and `osc_cnt` starting at 0. `osc_cnt` then rises by one per cycle up to OSC_CYC-1.
- R5: The seconds tick (`sec_irq`=1) qualifies only when `sec_en`=1 and `ext1_lvl`=1.
- R6: If the latched wake source is no longer qualified in the cycle where `osc_cnt` equals OSC_CYC-1, the block returns to power-down.
- R7: If the latched source is still qualified at the end of the window and outranks the interrupt in service, the block enters run. `cpu_clk_en` becomes 1, and `wake_req` is high for exactly one cycle with `wake_src` naming the source: 0 for external 0, 1 for external 1, 2 for seconds.
- R8: If an interrupt of equal or higher rank is in service at the end of the window, the block enters idle (mode code 1), with `osc_en`=1, `cpu_clk_en`=0 and no `wake_req`. Rank is 2 for a source whose priority bit is 1 and 1 otherwise. The in-service rank is 2 if `svc_hi`, else 1 if `svc_lo`, else 0.
- R9: In idle, a qualified source whose rank exceeds the in-service rank moves the block to run with a one-cycle `wake_req` and its `wake_src`. Otherwise the block stays in idle.
- R10: Asynchronous reset (`rst_n`=0) forces run, `osc_en`=1, `cpu_clk_en`=1, `osc_cnt`=0 and `wake_req`=0.
- R11: When several sources qualify together, the highest rank wins. Ties go to external 0, then external 1, then seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running low-frequency clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | CPU power-down request |
| wdt_en | input | 1 | Watchdog running |
| ext0_n | input | 1 | External interrupt line 0, active low |
| ext0_en | input | 1 | External interrupt 0 enable |
| ext0_lvl | input | 1 | External 0 is level-sensitive |
| ext0_pri | input | 1 | External 0 high priority |
| ext1_n | input | 1 | External interrupt line 1, active low |
| ext1_en | input | 1 | External interrupt 1 enable |
| ext1_lvl | input | 1 | External 1 is level-sensitive |
| ext1_pri | input | 1 | External 1 high priority |
| sec_irq | input | 1 | Seconds tick pending |
| sec_en | input | 1 | Seconds interrupt enable |
| sec_pri | input | 1 | Seconds high priority |
| svc_hi | input | 1 | A high-priority interrupt is in service |
| svc_lo | input | 1 | A low-priority interrupt is in service |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| osc_cnt | output | $clog2(OSC_CYC) | Stabilization counter |
| mode | output | 2 | 0 run, 1 idle, 2 power-down, 3 oscillator wait |
| wake_req | output | 1 | One-cycle wake-up interrupt request |
| wake_src | output | 2 | Source of the last wake-up |

## Verification
The assertions assume that every input is synchronous to the low-frequency clock. They also assume that `pd_req` reaches the block only in run, as it would from an executing CPU. The bench changes inputs only on falling edges. It raises `pd_req` only while the block is in run, and holds the in-service flags steady across each stabilization window, so the rank comparison made at the end of the window is the one the bench predicts.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_PD   = 2'd2,
    ST_OSCW = 2'd3
  } pmode_t;

  localparam int NSRC = 3;

  // rank of a wake source: high-priority bit gives 2, else 1
  function automatic logic [1:0] src_rank(input logic pri);
    return pri ? 2'd2 : 2'd1;
  endfunction

  // rank of whatever is in service; 0 when nothing is
  function automatic logic [1:0] svc_rank(input logic hi, input logic lo);
    return hi ? 2'd2 : (lo ? 2'd1 : 2'd0);
  endfunction

  function automatic logic outranks(input logic pri, input logic hi, input logic lo);
    return src_rank(pri) > svc_rank(hi, lo);
  endfunction
endpackage

// File: rtl/wake_qual.sv
module wake_qual
  import pwr_seq_pkg::*;
(
  input  logic [NSRC-1:0] line_act,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_lvl,
  input  logic [NSRC-1:0] src_pri,
  output logic [NSRC-1:0] qual,
  output logic            qual_any,
  output logic [1:0]      win_idx,
  output logic            win_pri
);
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_q
      assign qual[g] = line_act[g] & src_en[g] & src_lvl[g];
    end
  endgenerate

  assign qual_any = |qual;

  always_comb begin
    logic found;
    found   = 1'b0;
    win_idx = 2'd0;
    win_pri = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i] && (!found || (src_pri[i] && !win_pri))) begin
        found   = 1'b1;
        win_idx = 2'(i);
        win_pri = src_pri[i];
      end
    end
  end
endmodule

// File: rtl/osc_timer.sv
module osc_timer #(
  parameter int OSC_CYC = 1024,
  localparam int CW = $clog2(OSC_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          done
);
  localparam logic [CW-1:0] LAST = CW'(OSC_CYC - 1);

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
    else             cnt <= '0;
  end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int OSC_CYC = 1024,
  localparam int CW = $clog2(OSC_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_req,
  input  logic          wdt_en,
  input  logic          ext0_n,
  input  logic          ext0_en,
  input  logic          ext0_lvl,
  input  logic          ext0_pri,
  input  logic          ext1_n,
  input  logic          ext1_en,
  input  logic          ext1_lvl,
  input  logic          ext1_pri,
  input  logic          sec_irq,
  input  logic          sec_en,
  input  logic          sec_pri,
  input  logic          svc_hi,
  input  logic          svc_lo,
  output logic          osc_en,
  output logic          cpu_clk_en,
  output logic [CW-1:0] osc_cnt,
  output logic [1:0]    mode,
  output logic          wake_req,
  output logic [1:0]    wake_src
);
  pmode_t            state, state_nx;
  logic [NSRC-1:0]   qual, src_pri;
  logic              qual_any, win_pri, tmr_done;
  logic [1:0]        win_idx, lat_src, lat_nx, src_nx;
  logic              wake_nx;
  logic              lat_alive, lat_pri;

  assign src_pri = {sec_pri, ext1_pri, ext0_pri};

  wake_qual u_qual (
    .line_act ({sec_irq, ~ext1_n, ~ext0_n}),
    .src_en   ({sec_en, ext1_en, ext0_en}),
    .src_lvl  ({ext1_lvl, ext1_lvl, ext0_lvl}),
    .src_pri  (src_pri),
    .qual     (qual),
    .qual_any (qual_any),
    .win_idx  (win_idx),
    .win_pri  (win_pri)
  );

  osc_timer #(.OSC_CYC(OSC_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_OSCW),
    .cnt   (osc_cnt),
    .done  (tmr_done)
  );

  assign lat_alive = (lat_src < 2'(NSRC)) && qual[lat_src];
  assign lat_pri   = (lat_src < 2'(NSRC)) && src_pri[lat_src];

  always_comb begin
    state_nx = state;
    lat_nx   = lat_src;
    src_nx   = wake_src;
    wake_nx  = 1'b0;
    unique case (state)
      ST_RUN:  if (pd_req && !wdt_en) state_nx = ST_PD;
      ST_PD:   if (qual_any) begin
                 state_nx = ST_OSCW;
                 lat_nx   = win_idx;
               end
      ST_OSCW: if (tmr_done) begin
                 if (!lat_alive)                              state_nx = ST_PD;
                 else if (!outranks(lat_pri, svc_hi, svc_lo)) state_nx = ST_IDLE;
                 else begin
                   state_nx = ST_RUN;
                   wake_nx  = 1'b1;
                   src_nx   = lat_src;
                 end
               end
      ST_IDLE: if (qual_any && outranks(win_pri, svc_hi, svc_lo)) begin
                 state_nx = ST_RUN;
                 wake_nx  = 1'b1;
                 src_nx   = win_idx;
               end
      default: state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      lat_src  <= 2'd0;
      wake_src <= 2'd0;
      wake_req <= 1'b0;
    end else begin
      state    <= state_nx;
      lat_src  <= lat_nx;
      wake_src <= src_nx;
      wake_req <= wake_nx;
    end
  end

  assign mode       = state;
  assign osc_en     = (state != ST_PD);
  assign cpu_clk_en = (state == ST_RUN);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int OSC_CYC = 1024,
  localparam int CW = $clog2(OSC_CYC)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pd_req,
  input logic          wdt_en,
  input logic [1:0]    mode,
  input logic          osc_en,
  input logic          cpu_clk_en,
  input logic [CW-1:0] osc_cnt,
  input logic          wake_req,
  input logic          qual_any,
  input logic          tmr_done
);
  AST_ENTRY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) == 2'd0) |-> $past(pd_req && !wdt_en)); // R1
  AST_WDT_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && pd_req && wdt_en) |=> (mode == 2'd0)); // R2
  AST_NO_UNQUAL_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !qual_any) |=> (mode == 2'd2)); // R3
  AST_WAIT_COUNTS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && $past(mode) == 2'd3) |-> (osc_cnt == CW'($past(osc_cnt) + 1'b1))); // R4
  AST_GATE_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) && $past(mode) == 2'd3) |-> $past(tmr_done)); // R7
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req); // R7
  AST_IDLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (osc_en && !cpu_clk_en)); // R8
endmodule

bind pwr_seq pwr_seq_chk #(.OSC_CYC(OSC_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pd_req     (pd_req),
  .wdt_en     (wdt_en),
  .mode       (mode),
  .osc_en     (osc_en),
  .cpu_clk_en (cpu_clk_en),
  .osc_cnt    (osc_cnt),
  .wake_req   (wake_req),
  .qual_any   (qual_any),
  .tmr_done   (tmr_done)
);

// File: tb/pwr_seq_tb.sv
`timescale 1ns/1ps
module pwr_seq_tb;
  localparam int N  = 8;
  localparam int CW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_req = 0, wdt_en = 0;
  logic ext0_n = 1, ext0_en = 0, ext0_lvl = 0, ext0_pri = 0;
  logic ext1_n = 1, ext1_en = 0, ext1_lvl = 0, ext1_pri = 0;
  logic sec_irq = 0, sec_en = 0, sec_pri = 0, svc_hi = 0, svc_lo = 0;
  logic osc_en, cpu_clk_en, wake_req;
  logic [CW-1:0] osc_cnt;
  logic [1:0] mode, wake_src;

  always #5 clk = ~clk;

  pwr_seq #(.OSC_CYC(N)) u_dut (.*);

  typedef struct {
    string      tag;
    logic [1:0] md;
    logic       osc, cg, wr;
    logic [1:0] src;
    int         cnt;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;

  // expected outputs, pushed after an edge, compared at the next falling edge
  task automatic tick(string tag, logic [1:0] md, logic wr = 0, logic [1:0] src = 0, int cnt = 0);
    item_t it;
    @(posedge clk);
    it.tag = tag; it.md = md; it.wr = wr; it.src = src; it.cnt = cnt;
    it.osc = (md != 2'd2);
    it.cg  = (md == 2'd0);
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (mode !== e.md || osc_en !== e.osc || cpu_clk_en !== e.cg || wake_req !== e.wr ||
          int'(osc_cnt) != e.cnt || (e.wr && wake_src !== e.src)) begin
        n_fail++;
        $display("FAIL %s: got mode=%0d osc=%0b clk=%0b wreq=%0b src=%0d cnt=%0d exp mode=%0d osc=%0b clk=%0b wreq=%0b src=%0d cnt=%0d",
                 e.tag, mode, osc_en, cpu_clk_en, wake_req, wake_src, osc_cnt,
                 e.md, e.osc, e.cg, e.wr, e.src, e.cnt);
      end
    end
  end

  // full stabilization window: entry tick already done, count 1..N-1
  task automatic wait_window(string tag);
    for (int k = 1; k < N; k++) tick(tag, 2'd3, 0, 0, k);
  endtask

  task automatic finish_run();
    @(negedge clk); @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R10: reset state
    tick("R10 reset", 2'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2: watchdog blocks entry
    wdt_en = 1; pd_req = 1;
    tick("R2 wdt blocks", 2'd0);
    tick("R2 still run", 2'd0);
    wdt_en = 0;
    tick("R1 enter pd", 2'd2);
    pd_req = 0;

    // R3: disabled or edge-configured lines do not wake
    ext0_n = 0; ext0_en = 1; ext0_lvl = 0;
    tick("R3 edge ext0", 2'd2);
    ext0_en = 0; ext0_lvl = 1;
    tick("R3 disabled ext0", 2'd2);
    // R5: seconds needs ext1 level
    sec_irq = 1; sec_en = 1; ext1_lvl = 0;
    tick("R5 sec no lvl", 2'd2);
    ext1_lvl = 1;
    tick("R4 wait entry", 2'd3);
    wait_window("R4 counting");
    tick("R5 sec wake", 2'd0, 1, 2'd2, 0);
    sec_irq = 0; sec_en = 0;
    tick("R7 pulse ends", 2'd0);

    // R6: line released during wait -> back to pd
    pd_req = 1; tick("R1 enter pd2", 2'd2); pd_req = 0;
    ext0_en = 1;
    tick("R4 ext0 wait", 2'd3);
    ext0_n = 1;
    wait_window("R6 counting");
    tick("R6 back to pd", 2'd2);

    // R11: higher-priority ext1 wins over ext0
    ext0_n = 0; ext1_n = 0; ext1_en = 1; ext1_pri = 1;
    tick("R11 wait", 2'd3);
    wait_window("R11 counting");
    tick("R11 ext1 wins", 2'd0, 1, 2'd1, 0);

    // R11: equal priority, ext0 wins
    ext1_pri = 0;
    pd_req = 1; tick("R1 enter pd3", 2'd2); pd_req = 0;
    tick("R11 tie wait", 2'd3);
    wait_window("R11 tie counting");
    tick("R11 ext0 tie", 2'd0, 1, 2'd0, 0);

    // R8: in-service of equal rank -> idle
    ext1_n = 1; ext1_en = 0; svc_lo = 1;
    pd_req = 1; tick("R1 enter pd4", 2'd2); pd_req = 0;
    tick("R8 wait", 2'd3);
    wait_window("R8 counting");
    tick("R8 idle", 2'd1);
    tick("R9 idle holds", 2'd1);
    // R9: higher rank releases idle
    ext0_pri = 1;
    tick("R9 idle exit", 2'd0, 1, 2'd0, 0);

    // R8: high-rank service blocks even a high-priority source
    svc_lo = 0; svc_hi = 1;
    pd_req = 1; tick("R1 enter pd5", 2'd2); pd_req = 0;
    tick("R8 hi wait", 2'd3);
    wait_window("R8 hi counting");
    tick("R8 hi idle", 2'd1);
    tick("R9 no exit", 2'd1);

    // R10: reset from idle
    rst_n = 0;
    #1;
    n_chk++;
    if (mode !== 2'd0 || cpu_clk_en !== 1'b1 || osc_cnt !== '0 || wake_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 async reset: got mode=%0d clk=%0b exp mode=0 clk=1", mode, cpu_clk_en);
    end
    finish_run();
  end
endmodule